// File: doc/BRIEF.md
# Power and Refresh Busy Sequencer

This block sequences the power and refresh operations of an electrophoretic panel controller. It takes decoded host commands and runs power-up, panel refresh, power-down and an automatic chain of all three. While any of these run, it holds an active-low busy output. Power-up first performs a temperature reading and then ramps the booster. Power-down discharges the supplies but keeps every setting. The temperature read, the booster ramp, the refresh waveform and the discharge are modelled as waits whose length in clock cycles is set by parameters.

The block also watches the frame-data state. A pulse marks each data plane as fully received. Once every plane of a frame has arrived, a frame-complete flag rises. A data-stop command that finds this flag set starts a refresh on its own. A command that arrives while busy is low is dropped and raises a sticky error bit. After the automatic chain ends, the block sits in deep sleep and ignores all commands until reset.

Top module: `pwr_refresh_seq`

## Requirements
- R1: After reset, busy_n is 1 and booster_on, frame_flag, cmd_err, deep_sleep, sensor_on and refresh_on are all 0.
- R2: Power-on (code 0x04) with the booster off drives busy_n low for T_SENSE+T_RAMP cycles, starting the cycle after acceptance. During the first T_SENSE cycles sensor_on is 1 and booster_on is 0. booster_on is 1 from then on.
- R3: Power-on while the booster is already on is accepted with no busy pulse and no change to booster_on.
- R4: Power-off (code 0x02) with the booster on drives busy_n low for T_OFF cycles and leaves booster_on at 0. With the booster off, it has no effect and causes no busy pulse.
- R5: frame_flag becomes 1 once every plane_done bit has pulsed since the last clear, in any order. A subset of the planes leaves it at 0.
- R6: Data-start (code 0x10) clears frame_flag and forgets any planes already received.
- R7: Data-stop (code 0x11) with frame_flag at 1 starts a refresh: busy_n is low for T_REFRESH cycles and frame_flag is cleared. With frame_flag at 0, it causes no busy pulse.
- R8: Refresh (code 0x12) drives busy_n low for T_REFRESH cycles with refresh_on at 1 throughout, and clears frame_flag.
- R9: Auto (code 0x17) produces one unbroken busy pulse covering power-on (skipped when the booster is already on), refresh and power-off. After that pulse, deep_sleep is 1, busy_n is 1 and booster_on is 0.
- R10: In deep sleep every command is ignored: no busy pulse, no error and no change to booster_on. Only reset leaves deep sleep.
- R11: A command presented while busy_n is 0 is dropped. The running operation keeps its length, and cmd_err becomes 1 and stays 1 until reset.
- R12: In the idle state, a code outside the listed set is ignored: no busy pulse, no error and no change to booster_on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| plane_done | input | N_PLANES | One pulse per data plane fully received |
| busy_n | output | 1 | Low while an operation runs |
| booster_on | output | 1 | Booster enabled |
| sensor_on | output | 1 | Temperature reading in progress |
| refresh_on | output | 1 | Refresh waveform in progress |
| deep_sleep | output | 1 | Deep sleep reached after the auto chain |
| frame_flag | output | 1 | All planes of the frame received |
| cmd_err | output | 1 | Sticky: a command was dropped while busy |

## Verification
The checker tests several rules on every cycle. No command goes unflagged while busy is low, and the error bit never clears by itself. Sensing never overlaps an enabled booster, and refresh and sensing only happen while busy is low. A refresh always begins with the frame flag clear. The booster only drops at the end of a busy period, and deep sleep holds once reached with the booster off. The exact lengths of the busy pulses, the no-effect cases (repeated power-on, power-off when already off, unknown codes, data-stop on an incomplete frame, commands in deep sleep) and the chaining of the auto sequence into one pulse can only be shown by the bench's scenarios, which measure each busy pulse against a queue of expected lengths.

// File: rtl/psq_pkg.sv
package psq_pkg;

   localparam logic [7:0] OP_PWR_ON  = 8'h04;
   localparam logic [7:0] OP_PWR_OFF = 8'h02;
   localparam logic [7:0] OP_DSTART  = 8'h10;
   localparam logic [7:0] OP_DSTOP   = 8'h11;
   localparam logic [7:0] OP_REFRESH = 8'h12;
   localparam logic [7:0] OP_AUTO    = 8'h17;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SENSE,
      ST_RAMP,
      ST_REFRESH,
      ST_DISCHG,
      ST_SLEEP
   } seq_state_e;

   typedef struct packed {
      logic pwr_on;
      logic pwr_off;
      logic dstart;
      logic dstop;
      logic refresh;
      logic auto_go;
   } cmd_hit_t;

endpackage

// File: rtl/psq_cmd_decode.sv
module psq_cmd_decode
   import psq_pkg::*;
(
   input  logic       valid,
   input  logic       accept,
   input  logic [7:0] code,
   output cmd_hit_t   hit
);
   logic take;
   assign take = valid & accept;

   always_comb begin
      hit         = '0;
      hit.pwr_on  = take && (code == OP_PWR_ON);
      hit.pwr_off = take && (code == OP_PWR_OFF);
      hit.dstart  = take && (code == OP_DSTART);
      hit.dstop   = take && (code == OP_DSTOP);
      hit.refresh = take && (code == OP_REFRESH);
      hit.auto_go = take && (code == OP_AUTO);
   end
endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/psq_frame_track.sv
module psq_frame_track #(
   parameter int N_PLANES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PLANES-1:0] plane_done,
   input  logic                clear,
   output logic                complete
);
   logic [N_PLANES-1:0] seen;

   for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             seen[p] <= 1'b0;
         else if (clear)         seen[p] <= 1'b0;
         else if (plane_done[p]) seen[p] <= 1'b1;
      end
   end

   assign complete = &seen;
endmodule

// File: rtl/pwr_refresh_seq.sv
module pwr_refresh_seq
   import psq_pkg::*;
#(
   parameter int N_PLANES  = 2,
   parameter int T_SENSE   = 6,
   parameter int T_RAMP    = 10,
   parameter int T_REFRESH = 40,
   parameter int T_OFF     = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_code,
   input  logic [N_PLANES-1:0] plane_done,
   output logic                busy_n,
   output logic                booster_on,
   output logic                sensor_on,
   output logic                refresh_on,
   output logic                deep_sleep,
   output logic                frame_flag,
   output logic                cmd_err
);
   localparam int T_MAX_A = (T_SENSE > T_RAMP) ? T_SENSE : T_RAMP;
   localparam int T_MAX_B = (T_REFRESH > T_OFF) ? T_REFRESH : T_OFF;
   localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
   localparam int TW      = (T_MAX < 2) ? 1 : $clog2(T_MAX);

   if (N_PLANES < 1) begin : g_bad_planes
      $error("N_PLANES must be at least 1");
   end
   if (T_SENSE < 1 || T_RAMP < 1 || T_REFRESH < 1 || T_OFF < 1) begin : g_bad_time
      $error("every duration must be at least one cycle");
   end

   localparam logic [TW-1:0] LD_SENSE   = TW'(T_SENSE - 1);
   localparam logic [TW-1:0] LD_RAMP    = TW'(T_RAMP - 1);
   localparam logic [TW-1:0] LD_REFRESH = TW'(T_REFRESH - 1);
   localparam logic [TW-1:0] LD_OFF     = TW'(T_OFF - 1);

   seq_state_e    state, state_nx;
   logic          chain, chain_nx;
   logic          boost_nx;
   logic          err_q;
   logic          idle;
   logic          running;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_done;
   logic          flag_clr;
   logic          frame_ok;
   cmd_hit_t      hit;

   assign idle    = (state == ST_IDLE);
   assign running = (state != ST_IDLE) && (state != ST_SLEEP);

   psq_cmd_decode u_dec (
      .valid  (cmd_valid),
      .accept (idle),
      .code   (cmd_code),
      .hit    (hit)
   );

   psq_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   psq_frame_track #(.N_PLANES(N_PLANES)) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .plane_done (plane_done),
      .clear      (flag_clr),
      .complete   (frame_ok)
   );

   always_comb begin
      state_nx = state;
      chain_nx = chain;
      boost_nx = booster_on;
      tmr_load = 1'b0;
      tmr_val  = '0;
      flag_clr = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if ((hit.pwr_on || hit.auto_go) && !booster_on) begin
               state_nx = ST_SENSE;
               chain_nx = hit.auto_go;
               tmr_load = 1'b1;
               tmr_val  = LD_SENSE;
            end else if (hit.refresh || hit.auto_go ||
                         (hit.dstop && frame_ok)) begin
               state_nx = ST_REFRESH;
               chain_nx = hit.auto_go;
               tmr_load = 1'b1;
               tmr_val  = LD_REFRESH;
               flag_clr = 1'b1;
            end else if (hit.pwr_off && booster_on) begin
               state_nx = ST_DISCHG;
               chain_nx = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = LD_OFF;
            end else if (hit.dstart) begin
               flag_clr = 1'b1;
            end
         end
         ST_SENSE: begin
            if (tmr_done) begin
               state_nx = ST_RAMP;
               boost_nx = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = LD_RAMP;
            end
         end
         ST_RAMP: begin
            if (tmr_done) begin
               if (chain) begin
                  state_nx = ST_REFRESH;
                  tmr_load = 1'b1;
                  tmr_val  = LD_REFRESH;
                  flag_clr = 1'b1;
               end else begin
                  state_nx = ST_IDLE;
               end
            end
         end
         ST_REFRESH: begin
            if (tmr_done) begin
               if (chain) begin
                  state_nx = ST_DISCHG;
                  tmr_load = 1'b1;
                  tmr_val  = LD_OFF;
               end else begin
                  state_nx = ST_IDLE;
               end
            end
         end
         ST_DISCHG: begin
            if (tmr_done) begin
               boost_nx = 1'b0;
               state_nx = chain ? ST_SLEEP : ST_IDLE;
               chain_nx = 1'b0;
            end
         end
         ST_SLEEP: begin
            state_nx = ST_SLEEP;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         chain      <= 1'b0;
         booster_on <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         state      <= state_nx;
         chain      <= chain_nx;
         booster_on <= boost_nx;
         if (cmd_valid && running) err_q <= 1'b1;
      end
   end

   assign busy_n     = ~running;
   assign sensor_on  = (state == ST_SENSE);
   assign refresh_on = (state == ST_REFRESH);
   assign deep_sleep = (state == ST_SLEEP);
   assign frame_flag = frame_ok;
   assign cmd_err    = err_q;
endmodule

// File: rtl/pwr_refresh_seq_chk.sv
module pwr_refresh_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy_n,
   input logic booster_on,
   input logic sensor_on,
   input logic refresh_on,
   input logic deep_sleep,
   input logic frame_flag,
   input logic cmd_err
);
   a_r11_busy_cmd_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy_n) |=> cmd_err);

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   a_r2_sense_before_boost: assert property (@(posedge clk) disable iff (!rst_n)
      sensor_on |-> (!booster_on && !busy_n));

   a_r8_refresh_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_on |-> !busy_n);

   a_r7_refresh_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_on) |-> !frame_flag);

   a_r4_boost_drops_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(booster_on) |-> $past(!busy_n));

   a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      deep_sleep |-> (busy_n && !booster_on));

   a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      deep_sleep |=> deep_sleep);
endmodule

bind pwr_refresh_seq pwr_refresh_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .busy_n     (busy_n),
   .booster_on (booster_on),
   .sensor_on  (sensor_on),
   .refresh_on (refresh_on),
   .deep_sleep (deep_sleep),
   .frame_flag (frame_flag),
   .cmd_err    (cmd_err)
);

// File: tb/pwr_refresh_seq_test.sv
module pwr_refresh_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP    = 2;
   localparam int TS    = 6;
   localparam int TR    = 10;
   localparam int TREF  = 40;
   localparam int TOFF  = 5;
   localparam int WDOG  = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [7:0]    cmd_code = 8'h00;
   logic [NP-1:0] plane_done = '0;
   logic busy_n, booster_on, sensor_on, refresh_on, deep_sleep, frame_flag, cmd_err;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int exp_q[$];
   int run_len = 0;
   bit done = 1'b0;

   pwr_refresh_seq #(
      .N_PLANES(NP), .T_SENSE(TS), .T_RAMP(TR), .T_REFRESH(TREF), .T_OFF(TOFF)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .plane_done(plane_done), .busy_n(busy_n), .booster_on(booster_on),
      .sensor_on(sensor_on), .refresh_on(refresh_on), .deep_sleep(deep_sleep),
      .frame_flag(frame_flag), .cmd_err(cmd_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: measures every busy pulse and compares to the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && !busy_n) run_len++;
      else if (run_len > 0) begin
         tests++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL busy pulse: actual %0d expected 0 (none queued)", run_len);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (run_len != e) begin
               fails++;
               $display("FAIL busy pulse: actual %0d expected %0d", run_len, e);
            end
         end
         run_len = 0;
      end
   end

   task automatic issue(input logic [7:0] code, input int exp_len);
      if (exp_len > 0) exp_q.push_back(exp_len);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = code;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic settle();
      while (!busy_n) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic plane(input int idx);
      @(negedge clk);
      plane_done[idx] = 1'b1;
      @(negedge clk);
      plane_done = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      wait (cyc > WDOG);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 busy_n", busy_n, 1);
      check("R1 booster", booster_on, 0);
      check("R1 flag", frame_flag, 0);
      check("R1 err", cmd_err, 0);
      check("R1 sleep", deep_sleep, 0);
      check("R1 sensor/refresh", sensor_on | refresh_on, 0);

      // R12 unknown code in idle
      issue(8'h55, 0);
      check("R12 no busy", busy_n, 1);
      repeat (2) @(negedge clk);
      check("R12 no err", cmd_err, 0);
      check("R12 booster", booster_on, 0);

      // R2 power-on
      issue(8'h04, TS + TR);
      check("R2 sensing first", sensor_on, 1);
      check("R2 booster off while sensing", booster_on, 0);
      repeat (TS) @(negedge clk);
      check("R2 sensing over", sensor_on, 0);
      check("R2 booster ramping", booster_on, 1);
      settle();
      check("R2 booster on after", booster_on, 1);

      // R3 power-on again
      issue(8'h04, 0);
      check("R3 no busy", busy_n, 1);
      check("R3 booster stays", booster_on, 1);

      // R5 frame flag
      plane(0);
      check("R5 one plane", frame_flag, 0);
      plane(0);
      check("R5 same plane twice", frame_flag, 0);
      plane(1);
      check("R5 both planes", frame_flag, 1);

      // R6 data-start clears
      issue(8'h10, 0);
      check("R6 flag cleared", frame_flag, 0);
      plane(1);
      check("R6 partial forgotten", frame_flag, 0);
      issue(8'h10, 0);

      // R7 data-stop with incomplete frame
      plane(1);
      issue(8'h11, 0);
      check("R7 no refresh on partial", busy_n, 1);
      repeat (2) @(negedge clk);
      check("R7 still idle", busy_n, 1);
      // R7 data-stop with complete frame
      plane(0);
      check("R5 reverse order", frame_flag, 1);
      issue(8'h11, TREF);
      check("R7 refresh started", refresh_on, 1);
      check("R7 flag cleared", frame_flag, 0);
      settle();

      // R8 explicit refresh
      plane(0);
      plane(1);
      issue(8'h12, TREF);
      check("R8 refresh on", refresh_on, 1);
      check("R8 flag cleared", frame_flag, 0);
      repeat (TREF - 1) @(negedge clk);
      check("R8 refresh last cycle", refresh_on, 1);
      settle();

      // R4 power-off
      issue(8'h02, TOFF);
      check("R4 busy", busy_n, 0);
      settle();
      check("R4 booster off", booster_on, 0);
      issue(8'h02, 0);
      check("R4 off when off", busy_n, 1);

      // R11 command while busy
      check("R11 err before", cmd_err, 0);
      issue(8'h12, TREF);
      repeat (3) @(negedge clk);
      issue(8'h04, 0);
      check("R11 err set", cmd_err, 1);
      settle();
      check("R11 dropped power-on", booster_on, 0);
      repeat (3) @(negedge clk);
      check("R11 err sticky", cmd_err, 1);

      // R9 auto from booster off
      do_reset();
      check("R1 err cleared by reset", cmd_err, 0);
      issue(8'h17, TS + TR + TREF + TOFF);
      settle();
      check("R9 sleep", deep_sleep, 1);
      check("R9 booster off", booster_on, 0);
      check("R9 busy_n", busy_n, 1);

      // R10 commands in sleep
      issue(8'h04, 0);
      issue(8'h12, 0);
      repeat (3) @(negedge clk);
      check("R10 no busy", busy_n, 1);
      check("R10 no err", cmd_err, 0);
      check("R10 booster", booster_on, 0);
      check("R10 still asleep", deep_sleep, 1);

      // R9 auto with booster already on
      do_reset();
      issue(8'h04, TS + TR);
      settle();
      issue(8'h17, TREF + TOFF);
      settle();
      check("R9 sleep after short chain", deep_sleep, 1);

      repeat (3) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule